// File: doc/BRIEF.md
# Threshold-Interrupt Parallel Port FIFO

A sixteen-entry byte queue between a host and a parallel-port engine. The host moves bytes through it by interrupt-driven programmed I/O rather than DMA. In the forward direction the host writes data bytes, or command bytes marked by a tag bit, and the port engine drains them. In the reverse direction the port engine fills the queue and the host reads it.

The block raises a level interrupt to ask for service. In the forward direction it asks when enough space is free. In the reverse direction it asks when enough bytes are waiting. A programmable threshold sets the point. The host must also have DMA disabled and the service mask clear.

The block shows full and empty status. It rejects transfers that would overflow or underflow the queue and records them in a sticky error flag. Changing the direction flushes the queue.

Top module: `pio_thresh_fifo`

## Requirements
- R1: After reset the queue is empty: `fifoEmpty`=1, `fifoFull`=0, `svcIrq`=0, `accessErr`=0.
- R2: Bytes leave the queue in the order they entered. The head entry is visible on `headByte`. `headIsCmd` is 1 when the head was written through `hostWrCmd`.
- R3: `fifoFull` (16 entries) and `fifoEmpty` (0 entries) reflect the occupancy on the clock edge that follows each accepted push or pop.
- R4: Forward direction (`revDir`=0): the host pushes and `perTake` pops. `svcIrq` is 1 when occupancy ≤ T, where T is the effective threshold.
- R5: Reverse direction (`revDir`=1): `perPut` pushes and `hostRd` pops. `svcIrq` is 1 when occupancy ≥ 16 − T.
- R6: Threshold values of 15 and above, including 16, behave exactly as 15. Values 0 to 14 are used as given, so a threshold of 0 raises the forward interrupt only when the queue is empty.
- R7: When `dmaEnable`=1 or `svcMask`=1, `svcIrq` is 0.
- R8: A push into a full queue or a pop from an empty queue is ignored and sets `accessErr`. `accessErr` stays set until `errClear` is pulsed. A set in the same cycle wins over a clear.
- R9: A change of `revDir` empties the queue. On the edge where the change is seen, `svcIrq` is forced to 0, and push or pop strobes in that cycle are ignored.
- R10: `svcIrq` is registered. It reflects the occupancy, threshold, direction and enables of the previous cycle.
- R11: In the reverse direction, `hostWrData` and `hostWrCmd` have no effect. In the forward direction, `perPut` and `hostRd` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| revDir | input | 1 | 0 = host to port, 1 = port to host |
| dmaEnable | input | 1 | DMA mode; blocks the interrupt |
| svcMask | input | 1 | Service mask; blocks the interrupt |
| thresh | input | 5 | Interrupt threshold (values of 15 and above fold to 15) |
| errClear | input | 1 | Clears the sticky error flag |
| hostWrData | input | 1 | Host data-byte write strobe |
| hostWrCmd | input | 1 | Host command-byte write strobe |
| hostRd | input | 1 | Host read (pop) strobe |
| hostByteIn | input | 8 | Host write byte |
| perPut | input | 1 | Port engine push strobe |
| perTake | input | 1 | Port engine pop strobe |
| perByteIn | input | 8 | Port engine byte |
| headByte | output | 8 | Byte at the head of the queue |
| headIsCmd | output | 1 | Head entry is a command byte |
| fifoFull | output | 1 | Queue holds 16 entries |
| fifoEmpty | output | 1 | Queue holds 0 entries |
| svcIrq | output | 1 | Service interrupt, level |
| accessErr | output | 1 | Sticky overflow/underflow flag |

## Verification
The forward compare is driven by filling the queue one byte at a time with thresholds 0, 12, 15 and 16. This separates ≤ from <, and shows whether 16 folds onto 15 at the occupancies 15 and 16. The reverse compare is swept from 0 to 16 bytes with threshold 12 and with a folded value of 20. This locates the 3-to-4 edge and the one-byte trigger. Mixed data and command writes followed by drains check order and tagging. Masked and DMA cases, wrong-side strobes, overflow, underflow and direction flips check that nothing else changes.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic fromPer;
    logic tagCmd;
  } fifoStrobe_t;
endpackage

// File: rtl/pio_fifo_store.sv
module pio_fifo_store
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BYTE_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       stb,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic [BYTE_W-1:0] perByte,
  output logic [BYTE_W-1:0] headByte,
  output logic              headTag,
  output logic [CW-1:0]     count
);
  logic [BYTE_W:0] mem [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic [BYTE_W:0] inWord;

  assign inWord = stb.fromPer ? {1'b0, perByte} : {stb.tagCmd, hostByte};

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= inWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headByte = mem[rdPtr][BYTE_W-1:0];
  assign headTag  = mem[rdPtr][BYTE_W];
endmodule

// File: rtl/pio_fifo_ctl.sv
module pio_fifo_ctl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             revDir,
  input  logic             dmaEnable,
  input  logic             svcMask,
  input  logic [THR_W-1:0] thresh,
  input  logic             errClear,
  input  logic             hostWrData,
  input  logic             hostWrCmd,
  input  logic             hostRd,
  input  logic             perPut,
  input  logic             perTake,
  input  logic [CW-1:0]    count,
  output fifoStrobe_t      stb,
  output logic             svcIrq,
  output logic             accessErr
);
  logic          prevDir;
  logic          pushReq, popReq, isFull, isEmpty, wantIrq;
  logic [CW-1:0] effThr, revNeed;

  assign isFull  = (count == CW'(DEPTH));
  assign isEmpty = (count == '0);

  // Threshold fold: anything at or above DEPTH-1 acts as DEPTH-1.
  assign effThr  = (thresh >= THR_W'(DEPTH - 1)) ? CW'(DEPTH - 1) : CW'(thresh);
  assign revNeed = CW'(DEPTH) - effThr;

  assign pushReq = revDir ? perPut : (hostWrData | hostWrCmd);
  assign popReq  = revDir ? hostRd : perTake;

  always_comb begin
    stb         = '0;
    stb.flush   = (revDir != prevDir);
    stb.fromPer = revDir;
    stb.tagCmd  = hostWrCmd & ~hostWrData;
    stb.push    = pushReq & ~isFull & ~stb.flush;
    stb.pop     = popReq & ~isEmpty & ~stb.flush;
  end

  always_comb begin
    wantIrq = 1'b0;
    if (!dmaEnable && !svcMask)
      wantIrq = revDir ? (count >= revNeed) : (count <= effThr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDir   <= 1'b0;
      svcIrq    <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      prevDir <= revDir;
      svcIrq  <= stb.flush ? 1'b0 : wantIrq;
      if (!stb.flush && ((pushReq && isFull) || (popReq && isEmpty)))
        accessErr <= 1'b1;
      else if (errClear)
        accessErr <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_thresh_fifo.sv
module pio_thresh_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BYTE_W = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              revDir,
  input  logic              dmaEnable,
  input  logic              svcMask,
  input  logic [THR_W-1:0]  thresh,
  input  logic              errClear,
  input  logic              hostWrData,
  input  logic              hostWrCmd,
  input  logic              hostRd,
  input  logic [BYTE_W-1:0] hostByteIn,
  input  logic              perPut,
  input  logic              perTake,
  input  logic [BYTE_W-1:0] perByteIn,
  output logic [BYTE_W-1:0] headByte,
  output logic              headIsCmd,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              svcIrq,
  output logic              accessErr
);
  fifoStrobe_t   stb;
  logic [CW-1:0] count;

  pio_fifo_ctl #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rstN(rstN), .revDir(revDir), .dmaEnable(dmaEnable),
    .svcMask(svcMask), .thresh(thresh), .errClear(errClear),
    .hostWrData(hostWrData), .hostWrCmd(hostWrCmd), .hostRd(hostRd),
    .perPut(perPut), .perTake(perTake), .count(count), .stb(stb),
    .svcIrq(svcIrq), .accessErr(accessErr)
  );

  pio_fifo_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) store_i (
    .clk(clk), .rstN(rstN), .stb(stb), .hostByte(hostByteIn),
    .perByte(perByteIn), .headByte(headByte), .headTag(headIsCmd),
    .count(count)
  );

  assign fifoFull  = (count == CW'(DEPTH));
  assign fifoEmpty = (count == '0);
endmodule

// File: rtl/pio_thresh_fifo_chk.sv
module pio_thresh_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          revDir,
  input logic          dmaEnable,
  input logic          svcMask,
  input logic          errClear,
  input logic          fifoFull,
  input logic          fifoEmpty,
  input logic          svcIrq,
  input logic          accessErr,
  input logic          flush,
  input logic [CW-1:0] count
);
  a_r3_full_empty_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (accessErr && !errClear) |=> accessErr);

  a_r7_irq_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEnable || svcMask) |=> !svcIrq);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (fifoEmpty && !svcIrq));

  a_r4_empty_fwd_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !revDir && !dmaEnable && !svcMask && fifoEmpty) |=> svcIrq);

  a_r5_empty_rev_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (revDir && fifoEmpty) |=> !svcIrq);
endmodule

bind pio_thresh_fifo pio_thresh_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .revDir(revDir), .dmaEnable(dmaEnable),
  .svcMask(svcMask), .errClear(errClear), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty), .svcIrq(svcIrq), .accessErr(accessErr),
  .flush(stb.flush), .count(count)
);

// File: tb/pio_thresh_fifo_tb.sv
module pio_thresh_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // entry = {dir, op[1:0], thresh[4:0], byte[7:0]}; op 0 idle, 1 push, 2 cmd push, 3 pop
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 2'd1, 5'd12, 8'hA1}, {1'b0, 2'd2, 5'd12, 8'hB2},
    {1'b0, 2'd1, 5'd12, 8'hC3}, {1'b0, 2'd3, 5'd12, 8'h00},
    {1'b0, 2'd3, 5'd12, 8'h00}, {1'b0, 2'd3, 5'd12, 8'h00},
    {1'b0, 2'd1, 5'd0,  8'h11}, {1'b0, 2'd3, 5'd0,  8'h00},
    {1'b1, 2'd1, 5'd12, 8'h01}, {1'b1, 2'd1, 5'd12, 8'h02},
    {1'b1, 2'd1, 5'd12, 8'h03}, {1'b1, 2'd2, 5'd12, 8'hEE},
    {1'b1, 2'd1, 5'd12, 8'h04}, {1'b1, 2'd1, 5'd12, 8'h05},
    {1'b1, 2'd3, 5'd12, 8'h00}, {1'b1, 2'd1, 5'd20, 8'h06}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic revDir = 0, dmaEnable = 0, svcMask = 0, errClear = 0;
  logic [4:0] thresh = 5'd12;
  logic hostWrData = 0, hostWrCmd = 0, hostRd = 0, perPut = 0, perTake = 0;
  logic [7:0] hostByteIn = 0, perByteIn = 0;
  logic [7:0] headByte;
  logic headIsCmd, fifoFull, fifoEmpty, svcIrq, accessErr;

  int errors = 0, checks = 0;
  bit done = 0;
  int mCount = 0;
  logic [8:0] mQ [16];
  logic mDir = 0, mErr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pio_thresh_fifo dut_i (
    .clk(clk), .rstN(rstN), .revDir(revDir), .dmaEnable(dmaEnable),
    .svcMask(svcMask), .thresh(thresh), .errClear(errClear),
    .hostWrData(hostWrData), .hostWrCmd(hostWrCmd), .hostRd(hostRd),
    .hostByteIn(hostByteIn), .perPut(perPut), .perTake(perTake),
    .perByteIn(perByteIn), .headByte(headByte), .headIsCmd(headIsCmd),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .svcIrq(svcIrq),
    .accessErr(accessErr)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expIrq(input logic [4:0] th);
    int te = (th >= 15) ? 15 : int'(th);
    if (dmaEnable || svcMask) return 1'b0;
    return mDir ? (mCount >= 16 - te) : (mCount <= te);
  endfunction

  task automatic step(input logic d, input logic [1:0] op, input logic [4:0] th,
                      input logic [7:0] b);
    bit flushed = 0;
    string reqTag = (d && op == 2) ? "R11" : "R3";
    @(negedge clk);
    if (op == 3 && mCount > 0 && d == mDir) begin
      check("R2 head byte", {1'b0, headByte}, {1'b0, mQ[0][7:0]});
      check("R2 head tag", {8'h0, headIsCmd}, {8'h0, mQ[0][8]});
    end
    revDir = d; thresh = th;
    hostByteIn = b; perByteIn = b;
    if (op == 1) begin if (d) perPut = 1; else hostWrData = 1; end
    if (op == 2) hostWrCmd = 1;
    if (op == 3) begin if (d) hostRd = 1; else perTake = 1; end
    if (d != mDir) begin
      mDir = d; mCount = 0; flushed = 1;
    end else if ((op == 1) || (op == 2 && !d)) begin
      if (mCount == 16) mErr = 1;
      else begin mQ[mCount] = {(op == 2), b}; mCount++; end
    end else if (op == 3) begin
      if (mCount == 0) mErr = 1;
      else begin
        for (int i = 0; i < 15; i++) mQ[i] = mQ[i+1];
        mCount--;
      end
    end
    @(negedge clk);
    hostWrData = 0; hostWrCmd = 0; hostRd = 0; perPut = 0; perTake = 0;
    check({reqTag, " empty"}, {8'h0, fifoEmpty}, {8'h0, mCount == 0});
    check({reqTag, " full"}, {8'h0, fifoFull}, {8'h0, mCount == 16});
    check("R8 err flag", {8'h0, accessErr}, {8'h0, mErr});
    if (flushed) check("R9 irq low at flush", {8'h0, svcIrq}, 9'h0);
    @(negedge clk);
    check(mDir ? "R5 irq rev (R10 timing)" : "R4 irq fwd (R10 timing)",
          {8'h0, svcIrq}, {8'h0, expIrq(th)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 empty", {8'h0, fifoEmpty}, 9'h1);
    check("R1 full", {8'h0, fifoFull}, 9'h0);
    check("R1 irq", {8'h0, svcIrq}, 9'h0);
    check("R1 err", {8'h0, accessErr}, 9'h0);
    rstN = 1;

    for (int i = 0; i < NVEC; i++)
      step(VEC[i][15], VEC[i][14:13], VEC[i][12:8], VEC[i][7:0]);

    // R4/R6: forward fill with threshold 15, then 16 must match
    step(1'b0, 2'd0, 5'd15, 8'h0);
    for (int i = 0; i < 16; i++) step(1'b0, 2'd1, 5'd15, 8'(8'h40 + i));
    step(1'b0, 2'd0, 5'd16, 8'h0);
    check("R6 thr16 at 16 bytes", {8'h0, svcIrq}, 9'h0);
    step(1'b0, 2'd3, 5'd16, 8'h0);
    check("R6 thr16 at 15 bytes", {8'h0, svcIrq}, 9'h1);
    step(1'b0, 2'd1, 5'd16, 8'h7F);
    // R8 overflow ignored, then clear
    step(1'b0, 2'd1, 5'd12, 8'hFF);
    check("R8 overflow sets err", {8'h0, accessErr}, 9'h1);
    @(negedge clk); errClear = 1; @(negedge clk); errClear = 0; mErr = 0;
    check("R8 err cleared", {8'h0, accessErr}, 9'h0);
    // R2 drain order, R4 at 12/13 boundary
    for (int i = 0; i < 16; i++) step(1'b0, 2'd3, 5'd12, 8'h0);
    step(1'b0, 2'd3, 5'd12, 8'h0);
    check("R8 underflow sets err", {8'h0, accessErr}, 9'h1);
    // R7 masking
    svcMask = 1; step(1'b0, 2'd0, 5'd12, 8'h0);
    check("R7 mask blocks", {8'h0, svcIrq}, 9'h0);
    svcMask = 0; dmaEnable = 1; step(1'b0, 2'd0, 5'd12, 8'h0);
    check("R7 dma blocks", {8'h0, svcIrq}, 9'h0);
    dmaEnable = 0;
    // R11: port-side strobes in forward do nothing
    @(negedge clk); perPut = 1; hostRd = 1; perByteIn = 8'h55;
    @(negedge clk); perPut = 0; hostRd = 0;
    check("R11 fwd port push ignored", {8'h0, fifoEmpty}, 9'h1);
    // R5: reverse sweep threshold 12
    for (int i = 0; i < 17; i++) step(1'b1, 2'd1, 5'd12, 8'(8'h80 + i));
    for (int i = 0; i < 16; i++) step(1'b1, 2'd3, 5'd12, 8'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule